// File: doc/BRIEF.md
# Flash Region Access Permission Checker

This block decides whether a flash access may go ahead. It splits the flash into regions. Each region has a base page and a limit page, and a page is 4 KB. Each region also has one read enable and one write enable. Three sources are ORed to give each enable: a permission loaded from the descriptor, a grant that software writes on behalf of the master that owns the region, and a security-override strap. A request carries a 25-bit flash address and an access kind. One clock later the block answers with allow or deny.

Software sees a 32-bit permission word and one 32-bit window word per region. Only the two grant bytes of the permission word can be written. A lock input sets a sticky lockdown flag, and after that the grant bytes no longer change. Only reset clears the flag. The descriptor permissions, the strap and the region windows are taken from their inputs only when the load strobe is high.

Top module: `flash_perm_chk`

## Requirements
- R1: After reset the permission word reads 0x00000202 (region 1 readable and writable), every region word reads 0x00000000, and rspValid and rspAllow are low.
- R2: The permission word is at byte offset 0x00. Region r is at byte offset 0x10+4r, with its base page in bits 12:0 and its limit page in bits 28:16. Reserved bits and unmapped offsets read zero, and writes to region words are ignored.
- R3: A write to offset 0x00 with byte enable 3 sets the per-master write grants from bits 31:24. A write with byte enable 2 sets the per-master read grants from bits 23:16. Only master bits 1, 2 and 3 are stored. Reserved master bits read zero, and a byte whose enable is low is left unchanged.
- R4: A pulse on lockSet sets a sticky lock. After that, grant writes are ignored. Only reset clears the lock.
- R5: Permission word bit r (read) and bit 8+r (write) for region r equal the loaded descriptor bit, OR the matching grant bit of master r when r is 1, 2 or 3, OR the loaded strap.
- R6: When descLoad is high, the descriptor permissions, the strap and the region base and limit values are sampled on that clock edge. Changes on these inputs at any other time have no effect.
- R7: An address lies in region r when addr[24:12] >= base and addr[24:12] <= limit. A region whose limit is below its base matches no address.
- R8: reqType 0 (read) needs read permission. reqType 1 (write) and reqType 2 (erase) need write permission. reqType 3 is always denied.
- R9: When regions overlap, the matching region with the lowest index decides. An address that matches no region is denied.
- R10: rspValid is high exactly in the cycle after a cycle in which reqValid is high, and rspAllow carries the decision in that cycle. rspAllow is low whenever rspValid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 8 | Register byte address (bits 1:0 ignored) |
| regWe | input | 1 | Register write enable |
| regBe | input | 4 | Register byte enables |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regAddr |
| lockSet | input | 1 | Sets the sticky grant lock |
| descLoad | input | 1 | Samples the descriptor and strap inputs |
| descRdPerm | input | 4 | Descriptor read permission per region |
| descWrPerm | input | 4 | Descriptor write permission per region |
| descBase | input | 52 | Base page per region, 13 bits each |
| descLimit | input | 52 | Limit page per region, 13 bits each |
| strapOverride | input | 1 | Security-override strap |
| reqValid | input | 1 | Request strobe |
| reqAddr | input | 25 | Request flash byte address |
| reqType | input | 2 | Access kind: 0 read, 1 write, 2 erase, 3 reserved |
| rspValid | output | 1 | Decision valid |
| rspAllow | output | 1 | Access allowed |

## Verification
A wrong grant, descriptor or strap bit shows up at once in the low half of the permission word. It also flips the allow bit for every request that falls in that region, one clock after the request. A wrong base or limit register shows up directly in the region word. It also moves the allow/deny edge in a page sweep, and the bench places its probes exactly on those edges. A broken lock is caught at the first grant write made after the lock, by reading the permission word back once the write has completed.

// File: rtl/flash_perm_pkg.sv
package flash_perm_pkg;

  // Access kind carried by a request
  typedef enum logic [1:0] {
    REQ_READ  = 2'd0,
    REQ_WRITE = 2'd1,
    REQ_ERASE = 2'd2,
    REQ_RSVD  = 2'd3
  } req_kind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrGrantW;   // update write-grant byte
    logic wrGrantR;   // update read-grant byte
    logic loadDesc;   // sample descriptor inputs
    logic checkReq;   // evaluate request this cycle
    logic locked;     // grant lock is in force
  } ctrl_strobe_t;

  // Masters whose grants take effect: 1 firmware, 2 management, 3 network
  localparam logic [7:0] LIVE_MASTERS = 8'b0000_1110;

  // Word index of the first region word (byte offset 0x10)
  localparam int REGION_WORD0 = 4;

  // Page granularity in address bits
  localparam int PAGE_SHIFT = 12;

endpackage

// File: rtl/fpc_ctrl.sv
module fpc_ctrl
  import flash_perm_pkg::*;
#(
  parameter int REG_AW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWe,
  input  logic [3:0]        regBe,
  input  logic              lockSet,
  input  logic              descLoad,
  input  logic              reqValid,
  output ctrl_strobe_t      strobes
);

  logic lockQ;
  logic permSel;
  logic unusedCtrl;

  assign unusedCtrl = ^{regAddr[1:0], regBe[1:0]};

  always_ff @(posedge clk) begin
    if (!rstN)        lockQ <= 1'b0;
    else if (lockSet) lockQ <= 1'b1;
  end

  assign permSel = regWe && (regAddr[REG_AW-1:2] == '0);

  always_comb begin
    strobes.wrGrantW = permSel && regBe[3] && !lockQ;
    strobes.wrGrantR = permSel && regBe[2] && !lockQ;
    strobes.loadDesc = descLoad;
    strobes.checkReq = reqValid;
    strobes.locked   = lockQ;
  end

  // R4
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockQ |=> lockQ);

endmodule

// File: rtl/fpc_datapath.sv
module fpc_datapath
  import flash_perm_pkg::*;
#(
  parameter int N_REGIONS = 4,
  parameter int ADDR_W    = 25,
  parameter int REG_AW    = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  ctrl_strobe_t                   strobes,
  input  logic [REG_AW-1:0]              regAddr,
  input  logic [31:0]                    regWdata,
  output logic [31:0]                    regRdata,
  input  logic [N_REGIONS-1:0]           descRdPerm,
  input  logic [N_REGIONS-1:0]           descWrPerm,
  input  logic [N_REGIONS*(ADDR_W-PAGE_SHIFT)-1:0] descBase,
  input  logic [N_REGIONS*(ADDR_W-PAGE_SHIFT)-1:0] descLimit,
  input  logic                           strapOverride,
  input  logic [ADDR_W-1:0]              reqAddr,
  input  logic [1:0]                     reqType,
  output logic                           rspValid,
  output logic                           rspAllow
);

  localparam int PAGE_W = ADDR_W - PAGE_SHIFT;
  localparam int WORD_W = REG_AW - 2;
  localparam logic [N_REGIONS-1:0] BOOT_REGION = N_REGIONS'(2);

  logic [7:0]           grantWQ, grantRQ;
  logic [N_REGIONS-1:0] dRdQ, dWrQ;
  logic                 strapQ;
  logic [PAGE_W-1:0]    baseQ  [N_REGIONS];
  logic [PAGE_W-1:0]    limitQ [N_REGIONS];
  logic [N_REGIONS-1:0] effRd, effWr, hit;
  logic [PAGE_W-1:0]    reqPage;
  logic [WORD_W-1:0]    wordIdx;
  logic                 anyHit, allowNext;
  logic                 unusedData;

  assign unusedData = ^{regWdata[15:0], reqAddr[PAGE_SHIFT-1:0], regAddr[1:0]};

  // Grant bytes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantWQ <= '0;
      grantRQ <= '0;
    end else begin
      if (strobes.wrGrantW) grantWQ <= regWdata[31:24] & LIVE_MASTERS;
      if (strobes.wrGrantR) grantRQ <= regWdata[23:16] & LIVE_MASTERS;
    end
  end

  // Descriptor-sourced state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dRdQ   <= BOOT_REGION;
      dWrQ   <= BOOT_REGION;
      strapQ <= 1'b0;
    end else if (strobes.loadDesc) begin
      dRdQ   <= descRdPerm;
      dWrQ   <= descWrPerm;
      strapQ <= strapOverride;
    end
  end

  assign reqPage = reqAddr[ADDR_W-1:PAGE_SHIFT];

  for (genvar r = 0; r < N_REGIONS; r++) begin : g_region
    always_ff @(posedge clk) begin
      if (!rstN) begin
        baseQ[r]  <= '0;
        limitQ[r] <= '0;
      end else if (strobes.loadDesc) begin
        baseQ[r]  <= descBase[r*PAGE_W +: PAGE_W];
        limitQ[r] <= descLimit[r*PAGE_W +: PAGE_W];
      end
    end
    assign effRd[r] = dRdQ[r] | (LIVE_MASTERS[r] & grantRQ[r]) | strapQ;
    assign effWr[r] = dWrQ[r] | (LIVE_MASTERS[r] & grantWQ[r]) | strapQ;
    assign hit[r]   = (limitQ[r] >= baseQ[r]) &&
                      (reqPage >= baseQ[r]) && (reqPage <= limitQ[r]);
  end

  // Register readback
  assign wordIdx = regAddr[REG_AW-1:2];

  always_comb begin
    regRdata = '0;
    if (wordIdx == '0)
      regRdata = {grantWQ, grantRQ, 8'(effWr), 8'(effRd)};
    for (int r = 0; r < N_REGIONS; r++) begin
      if (wordIdx == WORD_W'(REGION_WORD0 + r))
        regRdata = {16'(limitQ[r]), 16'(baseQ[r])};
    end
  end

  // Lowest-index matching region decides
  always_comb begin
    anyHit    = 1'b0;
    allowNext = 1'b0;
    for (int r = N_REGIONS - 1; r >= 0; r--) begin
      if (hit[r]) begin
        anyHit = 1'b1;
        unique case (req_kind_e'(reqType))
          REQ_READ:            allowNext = effRd[r];
          REQ_WRITE, REQ_ERASE: allowNext = effWr[r];
          default:             allowNext = 1'b0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspAllow <= 1'b0;
    end else begin
      rspValid <= strobes.checkReq;
      rspAllow <= strobes.checkReq && allowNext;
    end
  end

  // R4
  grant_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.locked |=> ($stable(grantWQ) && $stable(grantRQ)));

  // R10
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.checkReq |=> rspValid);

  // R10
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.checkReq |=> (!rspValid && !rspAllow));

  // R9
  nohit_deny_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.checkReq && !anyHit) |=> !rspAllow);

  // R6
  desc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadDesc |=> ($stable(dRdQ) && $stable(dWrQ) && $stable(strapQ)));

endmodule

// File: rtl/flash_perm_chk.sv
module flash_perm_chk
  import flash_perm_pkg::*;
#(
  parameter int N_REGIONS = 4,
  parameter int ADDR_W    = 25,
  parameter int REG_AW    = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [REG_AW-1:0]    regAddr,
  input  logic                 regWe,
  input  logic [3:0]           regBe,
  input  logic [31:0]          regWdata,
  output logic [31:0]          regRdata,
  input  logic                 lockSet,
  input  logic                 descLoad,
  input  logic [N_REGIONS-1:0] descRdPerm,
  input  logic [N_REGIONS-1:0] descWrPerm,
  input  logic [N_REGIONS*(ADDR_W-12)-1:0] descBase,
  input  logic [N_REGIONS*(ADDR_W-12)-1:0] descLimit,
  input  logic                 strapOverride,
  input  logic                 reqValid,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [1:0]           reqType,
  output logic                 rspValid,
  output logic                 rspAllow
);

  ctrl_strobe_t strobes;

  fpc_ctrl #(.REG_AW(REG_AW)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regAddr  (regAddr),
    .regWe    (regWe),
    .regBe    (regBe),
    .lockSet  (lockSet),
    .descLoad (descLoad),
    .reqValid (reqValid),
    .strobes  (strobes)
  );

  fpc_datapath #(
    .N_REGIONS (N_REGIONS),
    .ADDR_W    (ADDR_W),
    .REG_AW    (REG_AW)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .regAddr       (regAddr),
    .regWdata      (regWdata),
    .regRdata      (regRdata),
    .descRdPerm    (descRdPerm),
    .descWrPerm    (descWrPerm),
    .descBase      (descBase),
    .descLimit     (descLimit),
    .strapOverride (strapOverride),
    .reqAddr       (reqAddr),
    .reqType       (reqType),
    .rspValid      (rspValid),
    .rspAllow      (rspAllow)
  );

endmodule

// File: tb/flash_perm_chk_test.sv
`timescale 1ns/1ps
module flash_perm_chk_test;

  localparam int NR = 4;
  localparam int PW = 13;

  logic            clk = 1'b0;
  logic            rstN;
  logic [7:0]      regAddr;
  logic            regWe;
  logic [3:0]      regBe;
  logic [31:0]     regWdata;
  logic [31:0]     regRdata;
  logic            lockSet;
  logic            descLoad;
  logic [NR-1:0]   descRdPerm, descWrPerm;
  logic [NR*PW-1:0] descBase, descLimit;
  logic            strapOverride;
  logic            reqValid;
  logic [24:0]     reqAddr;
  logic [1:0]      reqType;
  logic            rspValid, rspAllow;

  int compared = 0;
  int mismatched = 0;

  // Bench model state
  logic [7:0]    mGrantW, mGrantR;
  logic [NR-1:0] mRd, mWr;
  logic          mStrap;
  logic [PW-1:0] mBase [NR];
  logic [PW-1:0] mLimit[NR];

  always #2.5 clk = ~clk;

  flash_perm_chk uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe), .regBe(regBe),
    .regWdata(regWdata), .regRdata(regRdata), .lockSet(lockSet),
    .descLoad(descLoad), .descRdPerm(descRdPerm), .descWrPerm(descWrPerm),
    .descBase(descBase), .descLimit(descLimit), .strapOverride(strapOverride),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqType(reqType),
    .rspValid(rspValid), .rspAllow(rspAllow)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [NR-1:0] effRd();
    for (int r = 0; r < NR; r++)
      effRd[r] = mRd[r] | ((r >= 1 && r <= 3) ? mGrantR[r] : 1'b0) | mStrap;
  endfunction

  function automatic logic [NR-1:0] effWr();
    for (int r = 0; r < NR; r++)
      effWr[r] = mWr[r] | ((r >= 1 && r <= 3) ? mGrantW[r] : 1'b0) | mStrap;
  endfunction

  function automatic logic [31:0] expPerm();
    return {mGrantW, mGrantR, 8'(effWr()), 8'(effRd())};
  endfunction

  function automatic logic expAllow(input logic [24:0] a, input logic [1:0] t);
    logic [PW-1:0] pg;
    logic dec;
    logic [NR-1:0] er, ew;
    pg = a[24:12];
    dec = 1'b0;
    er = effRd();
    ew = effWr();
    for (int r = NR - 1; r >= 0; r--) begin
      if (mLimit[r] >= mBase[r] && pg >= mBase[r] && pg <= mLimit[r])
        dec = (t == 2'd0) ? er[r] : (t == 2'd3) ? 1'b0 : ew[r];
    end
    return dec;
  endfunction

  task automatic readReg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic writeReg(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regBe = be; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic loadDesc();
    @(negedge clk);
    for (int r = 0; r < NR; r++) begin
      descBase[r*PW +: PW]  = mBase[r];
      descLimit[r*PW +: PW] = mLimit[r];
    end
    descRdPerm = mRd; descWrPerm = mWr; strapOverride = mStrap;
    descLoad = 1'b1;
    @(negedge clk);
    descLoad = 1'b0;
  endtask

  task automatic checkRegs(input string tag);
    logic [31:0] d;
    readReg(8'h00, d);
    chk({tag, " perm word"}, d, expPerm());
    for (int r = 0; r < NR; r++) begin
      readReg(8'(8'h10 + 4 * r), d);
      chk({tag, " region word"}, d, {16'(mLimit[r]), 16'(mBase[r])});
    end
  endtask

  task automatic request(input logic [24:0] a, input logic [1:0] t);
    @(negedge clk);
    reqAddr = a; reqType = t; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R10 rspValid after request", 32'(rspValid), 32'd1);
    chk("R7 R8 R9 decision", 32'(rspAllow), 32'(expAllow(a, t)));
    @(negedge clk);
    chk("R10 idle after response", 32'({rspValid, rspAllow}), 32'd0);
  endtask

  task automatic sweep();
    for (int pg = 0; pg <= 8'h34; pg++) begin
      for (int t = 0; t < 4; t++)
        request({13'(pg), 12'((pg * 37 + t * 1000) % 4096)}, 2'(t));
    end
    request({13'h1FFF, 12'hFFF}, 2'd0);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    mGrantW = '0; mGrantR = '0; mRd = 4'b0010; mWr = 4'b0010; mStrap = 1'b0;
    for (int r = 0; r < NR; r++) begin mBase[r] = '0; mLimit[r] = '0; end
  endtask

  initial begin
    #1_000_000;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rstN = 1'b0; regAddr = '0; regWe = 1'b0; regBe = '0; regWdata = '0;
    lockSet = 1'b0; descLoad = 1'b0; descRdPerm = '0; descWrPerm = '0;
    descBase = '0; descLimit = '0; strapOverride = 1'b0;
    reqValid = 1'b0; reqAddr = '0; reqType = '0;
    doReset();

    // R1 reset state
    readReg(8'h00, d);
    chk("R1 perm reset", d, 32'h0000_0202);
    readReg(8'h10, d);
    chk("R1 region0 reset", d, 32'h0);
    chk("R1 rspValid reset", 32'({rspValid, rspAllow}), 32'd0);
    checkRegs("R1");
    // R2 unmapped offset
    readReg(8'h08, d);
    chk("R2 unmapped offset", d, 32'h0);

    // Configuration: overlap r1/r2, disabled r3
    mBase[0] = 13'h000; mLimit[0] = 13'h000;
    mBase[1] = 13'h010; mLimit[1] = 13'h01F;
    mBase[2] = 13'h018; mLimit[2] = 13'h030;
    mBase[3] = 13'h005; mLimit[3] = 13'h002;
    mRd = 4'b0011; mWr = 4'b0001; mStrap = 1'b0;
    loadDesc();
    checkRegs("R2 R6 load");

    // R6 input change without strobe is ignored
    @(negedge clk);
    descRdPerm = 4'b1111; descWrPerm = 4'b1111; strapOverride = 1'b1;
    descBase = '1; descLimit = '0;
    @(negedge clk);
    @(negedge clk);
    checkRegs("R6 no strobe");

    // R2 region words are read-only
    writeReg(8'h14, 4'hF, 32'h1FFF_1FFF);
    checkRegs("R2 region write ignored");

    sweep();

    // R3 grant writes, reserved masters dropped
    writeReg(8'h00, 4'b1100, 32'hFFFF_FFFF);
    mGrantW = 8'h0E; mGrantR = 8'h0E;
    checkRegs("R3 R5 grants");
    sweep();

    // R3 byte enables
    writeReg(8'h00, 4'b0000, 32'h0);
    checkRegs("R3 no byte enable");
    writeReg(8'h00, 4'b0100, 32'h0);
    mGrantR = 8'h00;
    checkRegs("R3 read grant byte only");
    writeReg(8'h00, 4'b1000, 32'h0400_0000);
    mGrantW = 8'h04;
    checkRegs("R3 write grant byte only");

    // R4 lock
    @(negedge clk);
    lockSet = 1'b1;
    @(negedge clk);
    lockSet = 1'b0;
    writeReg(8'h00, 4'b1111, 32'hFFFF_FFFF);
    checkRegs("R4 locked write ignored");
    sweep();

    // R5 strap
    mStrap = 1'b1;
    loadDesc();
    checkRegs("R5 strap");
    sweep();

    // R4 reset clears lock; R1
    doReset();
    checkRegs("R1 R4 after reset");
    writeReg(8'h00, 4'b1100, 32'h0202_0000);
    mGrantW = 8'h02; mGrantR = 8'h02;
    checkRegs("R4 unlocked after reset");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule